// File: doc/BRIEF.md
# Windowed-Address GPIO Register Bank

This block is the register bank behind a general-purpose I/O expander. It has 28 physical ports, numbered 4 to 31, inside a 32-port address space. Ports 0 to 3 are virtual placeholders. Every port has a 2-bit mode field and an output latch. A single run bit decides whether the configured modes reach the pins or whether every pin is held as an input with its pullup off.

Software reaches the ports in two ways. It can address one port at a time. It can also open an eight-port window whose first port is any port number, with no alignment rule. Window bits that land on virtual ports or on port numbers above 31 are dropped. Reads return the pin level for ports acting as inputs and the latch value for ports acting as outputs.

The block drives registered output-enable, output-value and pullup-enable vectors toward the pad ring. Reads complete one clock after the request.

Top module: `gpio_window_bank`

## Requirements
- R1: After reset:
  - all output-enable, output-value and pullup-enable bits are 0;
  - the run bit reads 0;
  - every mode register reads 0xAA, i.e. all ports are inputs without pullup.
- R2: Addresses 0x09 to 0x0F are mode registers. Register a covers ports 4(a−8) to 4(a−8)+3. Port 4(a−8)+j sits in data bits [2j+1:2j]. A read returns the value last written.
- R3: Mode codes are:
  - 01: output, which sets output-enable;
  - 11: input with pullup, which sets pullup-enable;
  - 10: input without pullup;
  - 00: reserved, and acts as input without pullup.

  Output-enable and pullup-enable are never both set for the same port.
- R4: Addresses 0x20 to 0x3F access port (address − 0x20) alone. A write loads data bit 0 into that port's latch. A read returns the port level in bit 0, with bits 7..1 at 0.
- R5: Addresses 0x40 to 0x5F access eight ports starting at port s = address − 0x40, with no alignment. Data bit k maps to port s+k for both writes and reads.
- R6: Ports 0 to 3 and port numbers above 31 have no state. Writes to them are dropped, their read bits are 0, and their output-enable and pullup-enable bits stay 0.
- R7: The level read for a port is its latch value when the port is currently driving (mode 01 and run bit set). Otherwise it is the sampled pin level.
- R8: Address 0x04 holds the run bit in data bit 0, where 0 means shutdown. A read returns it in bit 0, and the other bits read as 0.
- R9: While the run bit is 0:
  - every output-enable and pullup-enable bit is 0;
  - mode registers and latches keep their values and still accept writes.

  Setting the run bit again applies the stored configuration.
- R10: Writes to any other address, including 0x07, change no state. Reads of these addresses return 0.
- R11: Read data and its valid flag appear one clock after the read request. Port outputs reflect a write two clock edges after the write is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write request |
| rd_en | input | 1 | Register read request |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| pin_in | input | 32 | Sampled pin levels, one per port |
| rdata | output | 8 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid |
| port_oe | output | 32 | Per-port output enable |
| port_out | output | 32 | Per-port output value |
| port_pu | output | 32 | Per-port pullup enable |

## Verification
The bench exercises the windowed path with three kinds of start point:
- A window starting on a virtual port shows that out-of-range bits are dropped on the low side.
- A window starting at port 29 shows the same on the high side.
- An aligned window at port 4 holds a mix of output and input ports, which separates latch values from pin levels in one byte.

Single-port accesses target an output port, an input port under two different pin patterns, and a virtual port. Mode writes use all four codes side by side, so output-enable and pullup decoding can be distinguished. A shutdown phase writes new configuration while the pins are forced to inputs, then checks that the stored setup returns when the run bit is set again.

// File: rtl/gpw_pkg.sv
package gpw_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned MODE_W = 2;

  localparam int ADR_CFG         = 'h04;
  localparam int ADR_MODE_BASE   = 'h08;
  localparam int ADR_SINGLE_BASE = 'h20;
  localparam int ADR_WIN_BASE    = 'h40;

  localparam logic [MODE_W-1:0] MD_RSVD  = 2'b00;
  localparam logic [MODE_W-1:0] MD_OUT   = 2'b01;
  localparam logic [MODE_W-1:0] MD_IN    = 2'b10;
  localparam logic [MODE_W-1:0] MD_IN_PU = 2'b11;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_CFG,
    ACC_MODE,
    ACC_SINGLE,
    ACC_WINDOW
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e  kind;
    logic [5:0] idx;
  } acc_t;
endpackage

// File: rtl/gpw_decode.sv
module gpw_decode
  import gpw_pkg::*;
#(
  parameter int NPORT      = 32,
  parameter int FIRST_PORT = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_t              acc
);
  localparam int PER_REG  = DATA_W / MODE_W;
  localparam int MODE_LO  = ADR_MODE_BASE + FIRST_PORT / PER_REG;
  localparam int MODE_HI  = ADR_MODE_BASE + NPORT / PER_REG - 1;

  always_comb begin
    int a;
    logic [7:0] d;
    a   = int'(addr);
    d   = '0;
    acc = '{kind: ACC_NONE, idx: '0};
    if (a == ADR_CFG) begin
      acc.kind = ACC_CFG;
    end else if (a >= MODE_LO && a <= MODE_HI) begin
      d        = 8'(a - ADR_MODE_BASE);
      acc.kind = ACC_MODE;
      acc.idx  = d[5:0];
    end else if (a >= ADR_SINGLE_BASE && a < ADR_SINGLE_BASE + NPORT) begin
      d        = 8'(a - ADR_SINGLE_BASE);
      acc.kind = ACC_SINGLE;
      acc.idx  = d[5:0];
    end else if (a >= ADR_WIN_BASE && a < ADR_WIN_BASE + NPORT) begin
      d        = 8'(a - ADR_WIN_BASE);
      acc.kind = ACC_WINDOW;
      acc.idx  = d[5:0];
    end
  end
endmodule

// File: rtl/gpw_mode_bank.sv
module gpw_mode_bank
  import gpw_pkg::*;
#(
  parameter int NPORT = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  acc_t                    acc,
  input  logic [DATA_W-1:0]       wdata,
  output logic [MODE_W*NPORT-1:0] mode_flat,
  output logic                    run
);
  localparam int MW = MODE_W * NPORT;

  logic [MW-1:0] field_mask;
  logic [MW-1:0] field_val;
  logic [8:0]    shamt;

  always_comb begin
    shamt      = {acc.idx, 3'b000};
    field_mask = {{(MW-DATA_W){1'b0}}, {DATA_W{1'b1}}} << shamt;
    field_val  = {{(MW-DATA_W){1'b0}}, wdata} << shamt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_flat <= {NPORT{MD_IN}};
      run       <= 1'b0;
    end else if (wr_en) begin
      if (acc.kind == ACC_MODE)
        mode_flat <= (mode_flat & ~field_mask) | (field_val & field_mask);
      if (acc.kind == ACC_CFG)
        run <= wdata[0];
    end
  end

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && acc.kind == ACC_MODE) |=> $stable(mode_flat)); // R10
endmodule

// File: rtl/gpw_latch_bank.sv
module gpw_latch_bank
  import gpw_pkg::*;
#(
  parameter int NPORT      = 32,
  parameter int FIRST_PORT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  acc_t              acc,
  input  logic [DATA_W-1:0] wdata,
  output logic [NPORT-1:0]  latch
);
  localparam int                EW    = NPORT + DATA_W;
  localparam logic [NPORT-1:0]  EXIST = {NPORT{1'b1}} << FIRST_PORT;

  logic [EW-1:0]    win_mask_ext;
  logic [EW-1:0]    win_val_ext;
  logic [NPORT-1:0] wmask;
  logic [NPORT-1:0] wval;

  always_comb begin
    win_mask_ext = {{NPORT{1'b0}}, {DATA_W{1'b1}}} << acc.idx;
    win_val_ext  = {{NPORT{1'b0}}, wdata} << acc.idx;
    wmask        = '0;
    wval         = '0;
    if (acc.kind == ACC_SINGLE) begin
      wmask = {{(NPORT-1){1'b0}}, 1'b1} << acc.idx;
      wval  = {NPORT{wdata[0]}};
    end else if (acc.kind == ACC_WINDOW) begin
      wmask = win_mask_ext[NPORT-1:0];
      wval  = win_val_ext[NPORT-1:0];
    end
    wmask = wmask & EXIST;
  end

  always_ff @(posedge clk) begin
    if (rst)
      latch <= '0;
    else if (wr_en)
      latch <= (latch & ~wmask) | (wval & wmask);
  end

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (acc.kind == ACC_SINGLE || acc.kind == ACC_WINDOW)) |=> $stable(latch)); // R10
  AST_VIRT_LATCH_ZERO: assert property (@(posedge clk) disable iff (rst)
    latch[FIRST_PORT-1:0] == '0); // R6
endmodule

// File: rtl/gpio_window_bank.sv
module gpio_window_bank
  import gpw_pkg::*;
#(
  parameter int NPORT      = 32,
  parameter int FIRST_PORT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        addr,
  input  logic [7:0]        wdata,
  input  logic [NPORT-1:0]  pin_in,
  output logic [7:0]        rdata,
  output logic              rvalid,
  output logic [NPORT-1:0]  port_oe,
  output logic [NPORT-1:0]  port_out,
  output logic [NPORT-1:0]  port_pu
);
  localparam int               EW    = NPORT + DATA_W;
  localparam int               MW    = MODE_W * NPORT;
  localparam logic [NPORT-1:0] EXIST = {NPORT{1'b1}} << FIRST_PORT;

  acc_t             acc;
  logic [MW-1:0]    mode_flat;
  logic             run;
  logic [NPORT-1:0] latch;
  logic [NPORT-1:0] eff_oe;
  logic [NPORT-1:0] eff_pu;
  logic [NPORT-1:0] level;
  logic [EW-1:0]    lev_shift;
  logic [MW-1:0]    mode_shift;
  logic [7:0]       rd_next;

  gpw_decode #(.NPORT(NPORT), .FIRST_PORT(FIRST_PORT)) dec_i (
    .addr (addr),
    .acc  (acc)
  );

  gpw_mode_bank #(.NPORT(NPORT)) mode_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .acc       (acc),
    .wdata     (wdata),
    .mode_flat (mode_flat),
    .run       (run)
  );

  gpw_latch_bank #(.NPORT(NPORT), .FIRST_PORT(FIRST_PORT)) latch_i (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .acc   (acc),
    .wdata (wdata),
    .latch (latch)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [MODE_W-1:0] md;
    assign md        = mode_flat[MODE_W*p +: MODE_W];
    assign eff_oe[p] = EXIST[p] && run && (md == MD_OUT);
    assign eff_pu[p] = EXIST[p] && run && (md == MD_IN_PU);
    assign level[p]  = EXIST[p] && (eff_oe[p] ? latch[p] : pin_in[p]);
  end

  always_comb begin
    lev_shift  = {{DATA_W{1'b0}}, level} >> acc.idx;
    mode_shift = mode_flat >> {acc.idx, 3'b000};
    unique case (acc.kind)
      ACC_CFG:    rd_next = {7'b0, run};
      ACC_MODE:   rd_next = mode_shift[7:0];
      ACC_SINGLE: rd_next = {7'b0, lev_shift[0]};
      ACC_WINDOW: rd_next = lev_shift[7:0];
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rvalid   <= 1'b0;
      port_oe  <= '0;
      port_out <= '0;
      port_pu  <= '0;
    end else begin
      rvalid   <= rd_en;
      rdata    <= rd_en ? rd_next : '0;
      port_oe  <= eff_oe;
      port_out <= latch;
      port_pu  <= eff_pu;
    end
  end

  AST_SHDN_FORCES_IN: assert property (@(posedge clk) disable iff (rst)
    !run |=> (port_oe == '0 && port_pu == '0)); // R9
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid); // R11
  AST_OE_PU_EXCL: assert property (@(posedge clk) disable iff (rst)
    (port_oe & port_pu) == '0); // R3
  AST_VIRT_PINS_IDLE: assert property (@(posedge clk) disable iff (rst)
    port_oe[FIRST_PORT-1:0] == '0 && port_pu[FIRST_PORT-1:0] == '0); // R6
endmodule

// File: tb/gpio_window_bank_tb_top.sv
module gpio_window_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [31:0] pin_in = 32'h9C3A_F0F5;
  logic [7:0]  rdata;
  logic        rvalid;
  logic [31:0] port_oe, port_out, port_pu;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [1:0]  m_mode [32];
  logic [31:0] m_lat;
  logic        m_run;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  gpio_window_bank dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .pin_in(pin_in), .rdata(rdata), .rvalid(rvalid),
    .port_oe(port_oe), .port_out(port_out), .port_pu(port_pu)
  );

  function automatic logic mlev(input int p);
    if (p < 4 || p > 31) return 1'b0;
    if (m_run && m_mode[p] == 2'b01) return m_lat[p];
    return pin_in[p];
  endfunction

  function automatic logic [7:0] mdl_read(input int a);
    logic [7:0] r = '0;
    if (a == 4) r = {7'b0, m_run};
    else if (a >= 9 && a <= 15) begin
      for (int j = 0; j < 4; j++) r[2*j +: 2] = m_mode[(a-8)*4+j];
    end else if (a >= 32 && a <= 63) r[0] = mlev(a-32);
    else if (a >= 64 && a <= 95) begin
      for (int k = 0; k < 8; k++) r[k] = mlev(a-64+k);
    end
    return r;
  endfunction

  task automatic mdl_write(input int a, input logic [7:0] d);
    if (a == 4) m_run = d[0];
    else if (a >= 9 && a <= 15) begin
      for (int j = 0; j < 4; j++) m_mode[(a-8)*4+j] = d[2*j +: 2];
    end else if (a >= 32 && a <= 63) begin
      if (a-32 >= 4) m_lat[a-32] = d[0];
    end else if (a >= 64 && a <= 95) begin
      for (int k = 0; k < 8; k++)
        if (a-64+k >= 4 && a-64+k <= 31) m_lat[a-64+k] = d[k];
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 8'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    mdl_write(a, d);
  endtask

  task automatic rd(input int a, input string tag);
    @(negedge clk);
    exp_q.push_back(mdl_read(a));
    tag_q.push_back(tag);
    rd_en = 1'b1; addr = 8'(a);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_ports(input string tag);
    logic [31:0] eo, ep;
    repeat (2) @(negedge clk);
    eo = '0; ep = '0;
    for (int p = 4; p < 32; p++) begin
      eo[p] = m_run && m_mode[p] == 2'b01;
      ep[p] = m_run && m_mode[p] == 2'b11;
    end
    check({tag, " oe"}, port_oe, eo);
    check({tag, " pu"}, port_pu, ep);
    check({tag, " out"}, port_out, m_lat);
  endtask

  // monitor: compares read results against the scoreboard queue
  always @(negedge clk) begin
    if (!rst && rvalid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R11 unexpected read actual=%h expected=none", rdata);
      end else begin
        check(tag_q.pop_front(), {24'b0, rdata}, {24'b0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 32; p++) m_mode[p] = 2'b10;
    m_lat = '0; m_run = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk_ports("R1 reset");
    rd('h04, "R1 run bit reset");
    rd('h09, "R1 mode reset 0x09");
    rd('h0F, "R1 mode reset 0x0F");
    // R8 run bit, other bits ignored
    wr('h04, 8'h01); rd('h04, "R8 run set");
    wr('h04, 8'hFE); rd('h04, "R8 run clear via 0xFE");
    wr('h04, 8'hFF); rd('h04, "R8 run 0xFF reads 0x01");
    // R2 R3 mode fields, all four codes
    wr('h09, 8'h55);
    wr('h0F, 8'b01_11_10_00);
    chk_ports("R3 mode decode");
    rd('h0F, "R2 mode readback");
    // R4 single port
    wr('h25, 8'hFF);
    chk_ports("R4 single write port5");
    rd('h25, "R4 single read output port");
    rd('h2C, "R7 single read input port pattern A");
    pin_in = 32'h63C5_0F0A;
    rd('h2C, "R7 single read input port pattern B");
    rd('h3C, "R7 reserved-code port reads pin");
    // R5 R6 unaligned windows
    wr('h43, 8'hFF);
    chk_ports("R6 window from virtual port 3");
    rd('h44, "R5 window at port 4 mixes latch and pin");
    rd('h43, "R6 window read with virtual bit 0");
    wr('h5D, 8'hFF);
    chk_ports("R6 window at port 29 upper bits dropped");
    rd('h5D, "R6 window read beyond port 31");
    wr('h4B, 8'hA5);
    rd('h4B, "R5 unaligned window at port 11");
    wr('h22, 8'h01);
    rd('h22, "R6 virtual single port reads 0");
    chk_ports("R6 virtual single write ignored");
    // R10 undefined addresses
    wr('h07, 8'hFF); wr('h08, 8'h00); wr('h10, 8'h00); wr('h60, 8'hFF);
    rd('h07, "R10 read 0x07");
    rd('h08, "R10 read 0x08");
    rd('h09, "R10 mode unchanged");
    chk_ports("R10 ports unchanged");
    // R9 shutdown
    wr('h04, 8'h00);
    chk_ports("R9 shutdown forces inputs");
    rd('h25, "R9 output port reads pin in shutdown");
    wr('h0A, 8'h57);
    wr('h30, 8'h01);
    rd('h0A, "R9 mode write in shutdown");
    wr('h04, 8'h01);
    chk_ports("R9 configuration restored");
    rd('h48, "R9 window after restore");
    repeat (4) @(negedge clk);
    check("R11 scoreboard drained", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule